// File: doc/BRIEF.md
# Polled Serial Port with Byte Queues

This block is a bus-attached asynchronous serial port for a small embedded processor. Software writes bytes into a transmit queue and reads received bytes from a receive queue through five word-spaced registers. It polls two level counters: the free space in the transmit queue and the bytes waiting in the receive queue. No status flags are involved. Line timing comes from one 16-bit divisor that gives the length of a whole bit period in bus clocks. There is no oversampling multiplier. For example, a 50 MHz bus clock with 230400 baud uses a divisor of 217.

The frame format is fixed: a low start bit, eight data bits with the least significant bit first, and a high stop bit. The line rests high between frames. The receiver finds the start edge, re-checks the line half a bit later, and then samples once per bit period. Two level-sensitive interrupt lines are provided, one for the receive side and one for the transmit side. Both queues are 16 entries deep by default. Bytes that do not fit are discarded. The divisor must be written with a value of 4 or more before traffic starts.

Top module: `serport_mmio`

## Requirements
- R1: After reset, txLine is high, txIrq is 1, rxIrq is 0, the divisor reads 217, the transmit-free register reads 16, the receive-count register reads 0 and the receive port reads 0.
- R2: Registers are selected by word index on busAddr: 0 divisor (bits 15:0, read/write), 1 transmit free entries, 2 receive byte count, 3 transmit data (write only), 4 receive data. Divisor bits above 15 are discarded on write. Unused bits, index 3 and indices 5 to 7 read as zero. Read data is combinational in the cycle busRe is high.
- R3: Index 1 reads 16 minus the transmit queue occupancy. A write to index 3 while the queue holds 16 bytes is dropped.
- R4: Index 2 reads the receive queue occupancy. A read of index 4 returns the oldest byte in bits 7:0 and removes it. When the queue is empty, such a read returns 0 and leaves the queue unchanged.
- R5: A queued byte is sent as a start bit of 0, then bits 0 to 7, then a stop bit of 1. Each bit lasts exactly divisor clocks. With the serializer idle, the start bit appears on the first clock edge after the write edge. Back-to-back frames are separated by one idle-high clock.
- R6: After a falling edge, the receiver re-checks the line half a divisor later. A low pulse shorter than that is ignored and stores nothing.
- R7: A received frame whose stop bit samples low is discarded.
- R8: A frame that completes while the receive queue holds 16 bytes is discarded. The stored bytes are unchanged.
- R9: rxIrq is high exactly while the receive queue is non-empty.
- R10: txIrq is high exactly while the transmit queue is empty and no frame is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Register write strobe |
| busRe | input | 1 | Register read strobe (pops at index 4) |
| busAddr | input | 3 | Register word index |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data |
| rxLine | input | 1 | Serial input, idles high |
| txLine | output | 1 | Serial output, idles high |
| rxIrq | output | 1 | Receive data waiting |
| txIrq | output | 1 | Transmitter fully drained |

## Verification
A wrong bit counter or timer in the serializer becomes visible on txLine within one bit period. It shows as a shifted edge or a wrong bit value, and the per-clock line comparison catches it in the cycle it occurs. A queue pointer or occupancy error does not appear on the line right away. It shows up at the next poll of a level register or of the receive port, or as an interrupt that rises or falls one clock early or late. The receiver cases (glitch, bad stop bit, full queue) are only observable through the receive count and data after the frame window closes, so they are checked right after each frame.

// File: rtl/serport_pkg.sv
package serport_pkg;

  localparam logic [2:0] REG_DIV    = 3'd0;
  localparam logic [2:0] REG_TXFREE = 3'd1;
  localparam logic [2:0] REG_RXCNT  = 3'd2;
  localparam logic [2:0] REG_TXDATA = 3'd3;
  localparam logic [2:0] REG_RXDATA = 3'd4;

  localparam int FRAME_BITS = 10;
  localparam int DATA_BITS  = 8;

  typedef struct packed {
    logic pushTx;
    logic popTx;
    logic shiftTx;
    logic pushRx;
    logic popRx;
    logic shiftRx;
    logic loadDiv;
  } serStrobe_t;

endpackage

// File: rtl/serport_fifo.sv
module serport_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    count,
  output logic             empty,
  output logic             full
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;

  assign head  = mem[rdPtr];
  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= wrPtr + 1'b1;
      if (pop)  rdPtr <= rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/serport_ctrl.sv
module serport_ctrl
  import serport_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWe,
  input  logic             busRe,
  input  logic [2:0]       busAddr,
  input  logic [DIV_W-1:0] divisor,
  input  logic             txEmpty,
  input  logic             txFull,
  input  logic             rxEmpty,
  input  logic             rxFull,
  input  logic             rxBit,
  output serStrobe_t       strobe,
  output logic             txIdle
);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rxState_t;

  logic             txBusy;
  logic [DIV_W-1:0] txTick;
  logic [3:0]       txBits;

  rxState_t         rxState;
  logic [DIV_W-1:0] rxTick;
  logic [3:0]       rxBits;
  logic             rxPrev;

  logic [DIV_W-1:0] fullPeriod;
  logic [DIV_W-1:0] halfPeriod;

  assign fullPeriod = divisor - 1'b1;
  assign halfPeriod = (divisor >> 1) - 1'b1;
  assign txIdle     = !txBusy;

  always_comb begin
    strobe         = '0;
    strobe.loadDiv = busWe && (busAddr == REG_DIV);
    strobe.pushTx  = busWe && (busAddr == REG_TXDATA) && !txFull;
    strobe.popRx   = busRe && (busAddr == REG_RXDATA) && !rxEmpty;
    strobe.popTx   = !txBusy && !txEmpty;
    strobe.shiftTx = txBusy && (txTick == '0);
    strobe.shiftRx = (rxState == RX_DATA) && (rxTick == '0);
    strobe.pushRx  = (rxState == RX_STOP) && (rxTick == '0) && rxBit && !rxFull;
  end

  // transmit bit timer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBusy <= 1'b0;
      txTick <= '0;
      txBits <= '0;
    end else if (strobe.popTx) begin
      txBusy <= 1'b1;
      txTick <= fullPeriod;
      txBits <= '0;
    end else if (txBusy) begin
      if (txTick == '0) begin
        if (txBits == 4'(FRAME_BITS - 1)) begin
          txBusy <= 1'b0;
        end else begin
          txBits <= txBits + 1'b1;
          txTick <= fullPeriod;
        end
      end else begin
        txTick <= txTick - 1'b1;
      end
    end
  end

  // receive sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      rxTick  <= '0;
      rxBits  <= '0;
      rxPrev  <= 1'b1;
    end else begin
      rxPrev <= rxBit;
      case (rxState)
        RX_IDLE: begin
          if (rxPrev && !rxBit) begin
            rxState <= RX_START;
            rxTick  <= halfPeriod;
          end
        end
        RX_START: begin
          if (rxTick == '0) begin
            if (!rxBit) begin
              rxState <= RX_DATA;
              rxTick  <= fullPeriod;
              rxBits  <= '0;
            end else begin
              rxState <= RX_IDLE;
            end
          end else begin
            rxTick <= rxTick - 1'b1;
          end
        end
        RX_DATA: begin
          if (rxTick == '0) begin
            rxTick <= fullPeriod;
            if (rxBits == 4'(DATA_BITS - 1)) rxState <= RX_STOP;
            else                             rxBits  <= rxBits + 1'b1;
          end else begin
            rxTick <= rxTick - 1'b1;
          end
        end
        default: begin
          if (rxTick == '0) rxState <= RX_IDLE;
          else              rxTick  <= rxTick - 1'b1;
        end
      endcase
    end
  end

  assert_frame_len_R5: assert property (@(posedge clk) disable iff (!rstN)
    (txBusy && txTick == '0 && txBits == 4'(FRAME_BITS - 1)) |=> !txBusy);

  assert_rx_push_ends_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pushRx |=> (rxState == RX_IDLE));

endmodule

// File: rtl/serport_dp.sv
module serport_dp
  import serport_pkg::*;
#(
  parameter int              DIV_W      = 16,
  parameter logic [DIV_W-1:0] DIV_RESET = 16'd217,
  parameter int              FIFO_DEPTH = 16,
  localparam int CW = $clog2(FIFO_DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  serStrobe_t       strobe,
  input  logic [2:0]       busAddr,
  input  logic [31:0]      busWdata,
  input  logic             rxLine,
  input  logic             txIdle,
  output logic [31:0]      busRdata,
  output logic             txLine,
  output logic [DIV_W-1:0] divisor,
  output logic             txEmpty,
  output logic             txFull,
  output logic             rxEmpty,
  output logic             rxFull,
  output logic             rxBit,
  output logic             rxIrq,
  output logic             txIrq
);

  localparam logic [CW-1:0] DEPTH_C = CW'(FIFO_DEPTH);

  logic [FRAME_BITS-1:0] txShift;
  logic [DATA_BITS-1:0]  rxShift;
  logic [DATA_BITS-1:0]  txHead, rxHead;
  logic [CW-1:0]         txCount, rxCount;
  logic [1:0]            rxSync;
  logic                  unusedHi;

  assign unusedHi = ^busWdata[31:DIV_W];

  serport_fifo #(.WIDTH(DATA_BITS), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rstN(rstN), .push(strobe.pushTx), .pop(strobe.popTx),
    .wdata(busWdata[DATA_BITS-1:0]), .head(txHead), .count(txCount),
    .empty(txEmpty), .full(txFull));

  serport_fifo #(.WIDTH(DATA_BITS), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rstN(rstN), .push(strobe.pushRx), .pop(strobe.popRx),
    .wdata(rxShift), .head(rxHead), .count(rxCount),
    .empty(rxEmpty), .full(rxFull));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divisor <= DIV_RESET;
      txShift <= '1;
      rxShift <= '0;
      rxSync  <= 2'b11;
    end else begin
      rxSync <= {rxSync[0], rxLine};
      if (strobe.loadDiv) divisor <= busWdata[DIV_W-1:0];
      if (strobe.popTx)        txShift <= {1'b1, txHead, 1'b0};
      else if (strobe.shiftTx) txShift <= {1'b1, txShift[FRAME_BITS-1:1]};
      if (strobe.shiftRx) rxShift <= {rxBit, rxShift[DATA_BITS-1:1]};
    end
  end

  assign rxBit  = rxSync[1];
  assign txLine = txShift[0];
  assign rxIrq  = !rxEmpty;
  assign txIrq  = txEmpty && txIdle;

  always_comb begin
    case (busAddr)
      REG_DIV:    busRdata = 32'(divisor);
      REG_TXFREE: busRdata = 32'(DEPTH_C - txCount);
      REG_RXCNT:  busRdata = 32'(rxCount);
      REG_RXDATA: busRdata = rxEmpty ? 32'd0 : 32'(rxHead);
      default:    busRdata = 32'd0;
    endcase
  end

  assert_tx_count_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.popTx && !strobe.pushTx) |=> (txCount == $past(txCount) - 1'b1));

  assert_no_pop_empty_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rxCount == '0) |-> !strobe.popRx);

  assert_start_bit_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.popTx |=> !txLine);

  assert_stop_high_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pushRx |-> rxBit);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rxCount == DEPTH_C) |-> !strobe.pushRx);

  assert_idle_high_R10: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |-> txLine);

endmodule

// File: rtl/serport_mmio.sv
module serport_mmio
  import serport_pkg::*;
#(
  parameter int               DIV_W      = 16,
  parameter logic [DIV_W-1:0] DIV_RESET  = 16'd217,
  parameter int               FIFO_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWe,
  input  logic        busRe,
  input  logic [2:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  input  logic        rxLine,
  output logic        txLine,
  output logic        rxIrq,
  output logic        txIrq
);

  serStrobe_t       strobe;
  logic [DIV_W-1:0] divisor;
  logic txEmpty, txFull, rxEmpty, rxFull, rxBit, txIdle;

  serport_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
    .divisor(divisor), .txEmpty(txEmpty), .txFull(txFull), .rxEmpty(rxEmpty),
    .rxFull(rxFull), .rxBit(rxBit), .strobe(strobe), .txIdle(txIdle));

  serport_dp #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET), .FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busAddr(busAddr),
    .busWdata(busWdata), .rxLine(rxLine), .txIdle(txIdle), .busRdata(busRdata),
    .txLine(txLine), .divisor(divisor), .txEmpty(txEmpty), .txFull(txFull),
    .rxEmpty(rxEmpty), .rxFull(rxFull), .rxBit(rxBit), .rxIrq(rxIrq),
    .txIrq(txIrq));

endmodule

// File: tb/serport_mmio_tb.sv
module serport_mmio_tb;

  localparam int DIV   = 8;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0, busRe = 1'b0;
  logic [2:0]  busAddr = 3'd0;
  logic [31:0] busWdata = 32'd0;
  logic [31:0] busRdata;
  logic        rxLine = 1'b1;
  logic        txLine, rxIrq, txIrq;

  int nCmp = 0, nBad = 0, cyc = 0;
  bit inFlight = 1'b0;

  // behavioural reference state
  byte unsigned txQ[$];
  byte unsigned rxQ[$];
  int           mDiv = 217;
  bit           mBusy = 1'b0;
  int           mIdx = 0, mCnt = 0;
  logic [9:0]   mFrame = '1;
  bit           wasFull;

  always #5 clk = ~clk;

  serport_mmio u_dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .rxLine(rxLine), .txLine(txLine),
    .rxIrq(rxIrq), .txIrq(txIrq));

  function automatic void chk(string tag, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endfunction

  function automatic logic [31:0] expRead(logic [2:0] a);
    case (a)
      3'd0: return 32'(mDiv);
      3'd1: return 32'(DEPTH - txQ.size());
      3'd2: return 32'(rxQ.size());
      3'd4: return (rxQ.size() > 0) ? 32'(rxQ[0]) : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic mLine();
    return mBusy ? mFrame[mIdx] : 1'b1;
  endfunction

  // reference model, advanced on every rising edge
  always @(posedge clk) begin
    cyc++;
    if (!rstN) begin
      txQ.delete(); rxQ.delete();
      mDiv = 217; mBusy = 1'b0; mIdx = 0; mCnt = 0;
    end else begin
      wasFull = (txQ.size() >= DEPTH);
      if (!mBusy && txQ.size() > 0) begin
        mFrame = {1'b1, txQ.pop_front(), 1'b0};
        mBusy = 1'b1; mIdx = 0; mCnt = mDiv - 1;
      end else if (mBusy) begin
        if (mCnt == 0) begin
          if (mIdx == 9) mBusy = 1'b0;
          else begin mIdx++; mCnt = mDiv - 1; end
        end else mCnt--;
      end
      if (busWe && busAddr == 3'd3 && !wasFull) txQ.push_back(busWdata[7:0]);
      if (busWe && busAddr == 3'd0) mDiv = int'(busWdata[15:0]);
      if (busRe && busAddr == 3'd4 && rxQ.size() > 0) void'(rxQ.pop_front());
    end
    if (cyc > 150000) begin
      nBad++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  // per-clock comparison of the line and interrupts
  always @(negedge clk) begin
    if (rstN) begin
      chk("R5 txLine", 32'(txLine), 32'(mLine()));
      chk("R10 txIrq", 32'(txIrq), 32'(txQ.size() == 0 && !mBusy));
      if (!inFlight) chk("R9 rxIrq", 32'(rxIrq), 32'(rxQ.size() > 0));
    end
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, string tag);
    @(negedge clk);
    busRe = 1'b1; busAddr = a;
    #1 chk(tag, busRdata, expRead(a));
    @(negedge clk);
    busRe = 1'b0;
  endtask

  task automatic sendRx(byte unsigned b, bit goodStop);
    logic [9:0] f;
    f = {goodStop, b, 1'b0};
    inFlight = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); rxLine = f[i];
      repeat (DIV - 1) @(negedge clk);
    end
    @(negedge clk); rxLine = 1'b1;
    repeat (DIV) @(negedge clk);
    if (goodStop && rxQ.size() < DEPTH) rxQ.push_back(b);
    inFlight = 1'b0;
  endtask

  task automatic drainTx();
    while (txQ.size() > 0 || mBusy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset state
    #1;
    chk("R1 txLine", 32'(txLine), 32'd1);
    chk("R1 txIrq", 32'(txIrq), 32'd1);
    chk("R1 rxIrq", 32'(rxIrq), 32'd0);
    rd(3'd0, "R1 divisor");
    rd(3'd1, "R1 txfree");
    rd(3'd2, "R1 rxcount");
    rd(3'd4, "R1 R4 empty rx read");

    // R2: divisor width and write-only / unused indices
    wr(3'd0, 32'hABCD_0000 | DIV);
    rd(3'd0, "R2 divisor upper bits dropped");
    rd(3'd3, "R2 tx port reads zero");
    rd(3'd6, "R2 unused index");

    // R5: single frame, then a short burst
    wr(3'd3, 32'hA5);
    drainTx();
    wr(3'd3, 32'h01); wr(3'd3, 32'h80); wr(3'd3, 32'h3C);
    rd(3'd1, "R3 txfree during burst");
    drainTx();

    // R3: overfill the transmit queue
    for (int i = 0; i < 18; i++) wr(3'd3, 32'(8'h10 + i));
    rd(3'd1, "R3 txfree full");
    drainTx();
    rd(3'd1, "R3 txfree drained");

    // R4: receive and pop
    sendRx(8'h3C, 1'b1);
    rd(3'd2, "R4 rxcount one");
    rd(3'd4, "R4 oldest byte");
    rd(3'd4, "R4 empty read zero");
    rd(3'd2, "R4 rxcount after empty read");

    // R6: short low glitch
    @(negedge clk) rxLine = 1'b0;
    @(negedge clk) rxLine = 1'b1;
    repeat (40) @(negedge clk);
    rd(3'd2, "R6 glitch ignored");

    // R7: framing error then a good frame
    sendRx(8'h55, 1'b0);
    rd(3'd2, "R7 bad stop dropped");
    sendRx(8'h81, 1'b1);
    rd(3'd4, "R7 next frame intact");

    // R8: receive overflow
    for (int i = 0; i < 17; i++) sendRx(byte'(8'hC0 + i), 1'b1);
    rd(3'd2, "R8 rxcount full");
    for (int i = 0; i < 16; i++) rd(3'd4, "R8 R4 order after overflow");
    rd(3'd2, "R8 rxcount emptied");

    // concurrent transmit and receive
    wr(3'd3, 32'h5A);
    sendRx(8'hE7, 1'b1);
    drainTx();
    rd(3'd4, "R4 byte during transmit");

    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule